// File: doc/BRIEF.md
# Multi-PID TLB Entry Matcher

This block decides whether one translation entry serves one memory access. An access is presented with its effective address, its kind (load, store or instruction fetch) and a translation context. The block compares the entry's tag, address-space bit and permission bits against that access. One clock later it returns a result code, hit and protection-fault flags, the permissions the entry grants, the merged physical address, and two syndrome bits for a fault handler.

The context can take one of two forms. In normal mode the access runs under the core's own state. The entry's process tag may match any of three process-ID registers, tried in a fixed order. Privilege comes from the problem-state bit, and the data address space comes from the data-space bit. In external mode the access runs on behalf of another context. Only the external process ID is compared. The privilege and data address-space bits come from that external context. A tag of zero marks a global entry, which matches in either mode. A larger unit instantiates one matcher per entry and scans them.

Top module: `tlb_entry_matcher`

## Requirements
- R1: A response is registered. `rsp_valid` is high in the cycle after `req_valid` was sampled high, and low otherwise. After reset `rsp_valid`=0, `hit`=0, `prot_fault`=0 and `result`=1.
- R2: In normal mode the entry tag is compared with `pid0` first. It is then compared with `pid1` only if `pid1` is nonzero, and then with `pid2` only if `pid2` is nonzero. Any of these matches satisfies the tag.
- R3: In external mode only `ext_pid` is compared with the tag. `pid0`, `pid1` and `pid2` have no effect.
- R4: An entry tag of zero matches any PID in both modes. The address matches when `ea` and `ent_epn` agree on every bit where `ent_mask` is 0. An entry with `ent_valid`=0 never matches.
- R5: `ent_perm` bits [2:0] are the supervisor permissions and bits [5:3] are the user permissions. Within each group, bit 0 is read, bit 1 is write and bit 2 is execute. The user group is used when the selected privilege bit is 1, and the supervisor group otherwise. The selected privilege bit is `msr_pr` in normal mode and `ext_pr` in external mode. On a match, `perm_out` is that group; otherwise it is 0.
- R6: For a fetch, `ent_ts` must equal `msr_is`. For data accesses, `ent_ts` must equal `msr_ds` in normal mode or `ext_as` in external mode. A mismatch is reported as no match.
- R7: `acc_type` uses these codes: 0 is load, 1 is store, 2 is fetch, and 3 is handled as a load. `result` uses these codes: 0 is hit, 1 is no match, 2 is a load or store that lacks read or write permission, and 3 is a fetch that lacks execute permission. `hit` is 1 only for code 0, and `prot_fault` is 1 only for codes 2 and 3.
- R8: `syn_store` is 1 when the access was a store. `syn_ext` is 1 when the access used the external context. Both follow the access regardless of the result.
- R9: On a hit, `pa` is `ent_rpn` on bits where `ent_mask` is 0 and `ea` on bits where `ent_mask` is 1. When there is no hit, `pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| acc_type | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| ea | input | 32 | Effective address |
| ext_mode | input | 1 | Use the external context |
| ext_pid | input | 8 | External process ID |
| ext_as | input | 1 | External data address-space bit |
| ext_pr | input | 1 | External privilege bit (1 = user) |
| msr_is | input | 1 | Core instruction address-space bit |
| msr_ds | input | 1 | Core data address-space bit |
| msr_pr | input | 1 | Core privilege bit (1 = user) |
| pid0 | input | 8 | Primary process ID |
| pid1 | input | 8 | Secondary process ID |
| pid2 | input | 8 | Tertiary process ID |
| ent_valid | input | 1 | Entry valid |
| ent_ts | input | 1 | Entry address-space bit |
| ent_tid | input | 8 | Entry process tag (0 = global) |
| ent_epn | input | 32 | Entry effective page address |
| ent_mask | input | 32 | Page-offset mask (1 = offset bit) |
| ent_rpn | input | 32 | Entry real page address |
| ent_perm | input | 6 | Supervisor [2:0] and user [5:3] x/w/r permissions |
| rsp_valid | output | 1 | Response valid |
| hit | output | 1 | Access translated and permitted |
| prot_fault | output | 1 | Matched but not permitted |
| result | output | 2 | Result code |
| perm_out | output | 3 | Granted x/w/r permissions |
| pa | output | 32 | Merged physical address |
| syn_store | output | 1 | Syndrome: store access |
| syn_ext | output | 1 | Syndrome: external context |

## Verification
The hardest cases to reach are the secondary-PID paths. With a global tag of zero, a zero-valued PID register can never be told apart from a skipped one. The stimulus therefore uses a nonzero tag and changes only which PID register holds it. It also places the tag in `pid0` while in external mode, to show that the normal registers are ignored there. A second hard case comes from privilege and address space having two sources. The tests drive conflicting core and external values together, so a wrong source choice flips the result code.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_DPROT = 2'd2,
        RES_XPROT = 2'd3
    } res_e;

    localparam int PERM_W = 3;
    localparam int PERM_R = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_X = 2;

endpackage

// File: rtl/tlbm_tag_match.sv
module tlbm_tag_match #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8,
    parameter int NUM_PID = 3
) (
    input  logic                           ext_mode,
    input  logic [PID_W-1:0]               ext_pid,
    input  logic [NUM_PID-1:0][PID_W-1:0]  pid_list,
    input  logic                           ent_valid,
    input  logic [PID_W-1:0]               ent_tid,
    input  logic [ADDR_W-1:0]              ent_epn,
    input  logic [ADDR_W-1:0]              ent_mask,
    input  logic [ADDR_W-1:0]              ent_rpn,
    input  logic [ADDR_W-1:0]              ea,
    output logic                           tag_ok,
    output logic [ADDR_W-1:0]              pa_merged
);

    logic [NUM_PID-1:0] cand_en;
    logic [NUM_PID-1:0] cand_hit;
    logic               tid_global;
    logic               ext_hit;
    logic               norm_hit;
    logic               addr_hit;

    // Normal-mode candidates: the first PID is always tried, the others
    // only when they hold a nonzero value.
    for (genvar i = 0; i < NUM_PID; i++) begin : g_cand
        if (i == 0) begin : g_first
            assign cand_en[i] = !ext_mode;
        end else begin : g_rest
            assign cand_en[i] = !ext_mode && (pid_list[i] != '0);
        end
        assign cand_hit[i] = cand_en[i] && (ent_tid == pid_list[i]);
    end

    always_comb begin
        tid_global = (ent_tid == '0);
        ext_hit    = ext_mode && (ent_tid == ext_pid);
        norm_hit   = |cand_hit;
        addr_hit   = (((ea ^ ent_epn) & ~ent_mask) == '0);
        tag_ok     = ent_valid && addr_hit && (tid_global || ext_hit || norm_hit);
        pa_merged  = (ent_rpn & ~ent_mask) | (ea & ent_mask);
    end

endmodule

// File: rtl/tlbm_perm_sel.sv
module tlbm_perm_sel
    import tlbm_pkg::*;
(
    input  acc_e               acc,
    input  logic               pr_sel,
    input  logic [2*PERM_W-1:0] ent_perm,
    output logic [PERM_W-1:0]  granted,
    output logic               allowed
);

    always_comb begin
        granted = pr_sel ? ent_perm[2*PERM_W-1:PERM_W] : ent_perm[PERM_W-1:0];
        unique case (acc)
            ACC_STORE: allowed = granted[PERM_WR];
            ACC_FETCH: allowed = granted[PERM_X];
            default:   allowed = granted[PERM_R];
        endcase
    end

endmodule

// File: rtl/tlbm_resolve.sv
module tlbm_resolve
    import tlbm_pkg::*;
(
    input  logic tag_ok,
    input  logic as_ok,
    input  logic allowed,
    input  logic is_fetch,
    output res_e result,
    output logic hit,
    output logic prot_fault
);

    logic matched;

    always_comb begin
        matched    = tag_ok && as_ok;
        hit        = matched && allowed;
        prot_fault = matched && !allowed;
        if (!matched) begin
            result = RES_MISS;
        end else if (!allowed) begin
            result = is_fetch ? RES_XPROT : RES_DPROT;
        end else begin
            result = RES_HIT;
        end
    end

endmodule

// File: rtl/tlb_entry_matcher.sv
module tlb_entry_matcher
    import tlbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        acc_type,
    input  logic [ADDR_W-1:0] ea,
    input  logic              ext_mode,
    input  logic [PID_W-1:0]  ext_pid,
    input  logic              ext_as,
    input  logic              ext_pr,
    input  logic              msr_is,
    input  logic              msr_ds,
    input  logic              msr_pr,
    input  logic [PID_W-1:0]  pid0,
    input  logic [PID_W-1:0]  pid1,
    input  logic [PID_W-1:0]  pid2,
    input  logic              ent_valid,
    input  logic              ent_ts,
    input  logic [PID_W-1:0]  ent_tid,
    input  logic [ADDR_W-1:0] ent_epn,
    input  logic [ADDR_W-1:0] ent_mask,
    input  logic [ADDR_W-1:0] ent_rpn,
    input  logic [5:0]        ent_perm,
    output logic              rsp_valid,
    output logic              hit,
    output logic              prot_fault,
    output logic [1:0]        result,
    output logic [2:0]        perm_out,
    output logic [ADDR_W-1:0] pa,
    output logic              syn_store,
    output logic              syn_ext
);

    localparam int NUM_PID = 3;

    typedef struct packed {
        logic              rsp_valid;
        logic              hit;
        logic              prot_fault;
        res_e              result;
        logic [PERM_W-1:0] perm;
        logic [ADDR_W-1:0] pa;
        logic              syn_store;
        logic              syn_ext;
    } state_t;

    state_t state_d, state_q;

    acc_e                          acc;
    logic [NUM_PID-1:0][PID_W-1:0] pid_list;
    logic                          pr_sel;
    logic                          as_sel;
    logic                          as_ok;
    logic                          is_fetch;
    logic                          tag_ok;
    logic [ADDR_W-1:0]             pa_merged;
    logic [PERM_W-1:0]             granted;
    logic                          allowed;
    res_e                          res_w;
    logic                          hit_w;
    logic                          prot_w;

    always_comb begin
        acc         = acc_e'(acc_type);
        pid_list[0] = pid0;
        pid_list[1] = pid1;
        pid_list[2] = pid2;
        is_fetch    = (acc == ACC_FETCH);
        pr_sel      = ext_mode ? ext_pr : msr_pr;
        as_sel      = is_fetch ? msr_is : (ext_mode ? ext_as : msr_ds);
        as_ok       = (ent_ts == as_sel);
    end

    tlbm_tag_match #(
        .ADDR_W  (ADDR_W),
        .PID_W   (PID_W),
        .NUM_PID (NUM_PID)
    ) i_tag (
        .ext_mode  (ext_mode),
        .ext_pid   (ext_pid),
        .pid_list  (pid_list),
        .ent_valid (ent_valid),
        .ent_tid   (ent_tid),
        .ent_epn   (ent_epn),
        .ent_mask  (ent_mask),
        .ent_rpn   (ent_rpn),
        .ea        (ea),
        .tag_ok    (tag_ok),
        .pa_merged (pa_merged)
    );

    tlbm_perm_sel i_perm (
        .acc      (acc),
        .pr_sel   (pr_sel),
        .ent_perm (ent_perm),
        .granted  (granted),
        .allowed  (allowed)
    );

    tlbm_resolve i_res (
        .tag_ok     (tag_ok),
        .as_ok      (as_ok),
        .allowed    (allowed),
        .is_fetch   (is_fetch),
        .result     (res_w),
        .hit        (hit_w),
        .prot_fault (prot_w)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        if (req_valid) begin
            state_d.rsp_valid  = 1'b1;
            state_d.hit        = hit_w;
            state_d.prot_fault = prot_w;
            state_d.result     = res_w;
            state_d.perm       = (tag_ok && as_ok) ? granted : '0;
            state_d.pa         = hit_w ? pa_merged : '0;
            state_d.syn_store  = (acc == ACC_STORE);
            state_d.syn_ext    = ext_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{rsp_valid: 1'b0, hit: 1'b0, prot_fault: 1'b0,
                         result: RES_MISS, perm: '0, pa: '0,
                         syn_store: 1'b0, syn_ext: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.rsp_valid;
    assign hit        = state_q.hit;
    assign prot_fault = state_q.prot_fault;
    assign result     = state_q.result;
    assign perm_out   = state_q.perm;
    assign pa         = state_q.pa;
    assign syn_store  = state_q.syn_store;
    assign syn_ext    = state_q.syn_ext;

endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] acc_type,
    input logic       ext_mode,
    input logic       ent_valid,
    input logic       rsp_valid,
    input logic       hit,
    input logic       prot_fault,
    input logic [1:0] result,
    input logic [2:0] perm_out,
    input logic       syn_store,
    input logic       syn_ext
);

    // R1
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R4
    invalid_entry_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!ent_valid)) |-> (result == 2'd1 && !hit));

    // R7
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, prot_fault}));

    // R7
    hit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (hit == (result == 2'd0)));

    // R5
    fetch_hit_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hit && $past(acc_type) == 2'd2) |-> perm_out[2]);

    // R8
    store_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (syn_store == ($past(acc_type) == 2'd1)));

    // R8
    ext_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (syn_ext == $past(ext_mode)));

endmodule

bind tlb_entry_matcher tlbm_checker i_tlbm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acc_type   (acc_type),
    .ext_mode   (ext_mode),
    .ent_valid  (ent_valid),
    .rsp_valid  (rsp_valid),
    .hit        (hit),
    .prot_fault (prot_fault),
    .result     (result),
    .perm_out   (perm_out),
    .syn_store  (syn_store),
    .syn_ext    (syn_ext)
);

// File: tb/test_tlb_entry_matcher.sv
`timescale 1ns/1ps
module test_tlb_entry_matcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid;
    logic [1:0]  acc_type;
    logic [31:0] ea;
    logic        ext_mode;
    logic [7:0]  ext_pid;
    logic        ext_as, ext_pr, msr_is, msr_ds, msr_pr;
    logic [7:0]  pid0, pid1, pid2;
    logic        ent_valid, ent_ts;
    logic [7:0]  ent_tid;
    logic [31:0] ent_epn, ent_mask, ent_rpn;
    logic [5:0]  ent_perm;
    logic        rsp_valid, hit, prot_fault, syn_store, syn_ext;
    logic [1:0]  result;
    logic [2:0]  perm_out;
    logic [31:0] pa;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tlb_entry_matcher i_tlb_entry_matcher (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
        .ea(ea), .ext_mode(ext_mode), .ext_pid(ext_pid), .ext_as(ext_as),
        .ext_pr(ext_pr), .msr_is(msr_is), .msr_ds(msr_ds), .msr_pr(msr_pr),
        .pid0(pid0), .pid1(pid1), .pid2(pid2), .ent_valid(ent_valid),
        .ent_ts(ent_ts), .ent_tid(ent_tid), .ent_epn(ent_epn),
        .ent_mask(ent_mask), .ent_rpn(ent_rpn), .ent_perm(ent_perm),
        .rsp_valid(rsp_valid), .hit(hit), .prot_fault(prot_fault),
        .result(result), .perm_out(perm_out), .pa(pa),
        .syn_store(syn_store), .syn_ext(syn_ext)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        req_valid = 0; acc_type = 2'd0; ea = 32'h1234_5678;
        ext_mode = 0; ext_pid = 8'h00; ext_as = 0; ext_pr = 0;
        msr_is = 0; msr_ds = 0; msr_pr = 0;
        pid0 = 8'h05; pid1 = 8'h00; pid2 = 8'h00;
        ent_valid = 1; ent_ts = 0; ent_tid = 8'h05;
        ent_epn = 32'h1234_5000; ent_mask = 32'h0000_0FFF;
        ent_rpn = 32'hABCD_E000; ent_perm = 6'b111111;
    endtask

    // Present one access and sample the registered response.
    task automatic run_access();
        @(negedge clk); req_valid = 1;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic t_reset();
        check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 reset hit", {31'd0, hit}, 32'd0);
        check("R1 reset result", {30'd0, result}, 32'd1);
        check("R1 reset prot_fault", {31'd0, prot_fault}, 32'd0);
    endtask

    task automatic t_basic();
        set_defaults(); run_access();
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check("R7 hit result", {30'd0, result}, 32'd0);
        check("R9 pa merge", pa, 32'hABCD_E678);
        @(negedge clk);
        check("R1 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_pid_order();
        set_defaults(); pid0 = 8'h03; pid1 = 8'h05; run_access();
        check("R2 pid1 hit", {30'd0, result}, 32'd0);
        set_defaults(); pid0 = 8'h03; pid1 = 8'h00; pid2 = 8'h05; run_access();
        check("R2 pid2 hit past zero pid1", {30'd0, result}, 32'd0);
        set_defaults(); pid0 = 8'h03; pid1 = 8'h04; pid2 = 8'h06; run_access();
        check("R2 no pid match", {30'd0, result}, 32'd1);
        check("R9 pa zero on miss", pa, 32'd0);
        set_defaults(); ent_tid = 8'h00; pid0 = 8'h09; run_access();
        check("R4 global tag", {31'd0, hit}, 32'd1);
    endtask

    task automatic t_ext();
        set_defaults(); ext_mode = 1; ext_pid = 8'h07; run_access();
        check("R3 pid0 ignored in ext", {30'd0, result}, 32'd1);
        set_defaults(); ext_mode = 1; ext_pid = 8'h07; ent_tid = 8'h07; pid0 = 8'h01; run_access();
        check("R3 ext pid hit", {31'd0, hit}, 32'd1);
        check("R8 ext syndrome", {31'd0, syn_ext}, 32'd1);
    endtask

    task automatic t_addr();
        set_defaults(); ea = 32'h1234_6678; run_access();
        check("R4 page bit mismatch", {30'd0, result}, 32'd1);
        set_defaults(); ent_valid = 0; run_access();
        check("R4 invalid entry", {30'd0, result}, 32'd1);
        set_defaults(); ent_mask = 32'h0000_FFFF; ea = 32'h1234_ABCD; run_access();
        check("R9 larger page merge", pa, 32'hABCD_ABCD);
    endtask

    task automatic t_priv();
        set_defaults(); ent_perm = 6'b001_110; msr_pr = 1; run_access();
        check("R5 user perms", {29'd0, perm_out}, 32'h1);
        check("R5 user load hit", {31'd0, hit}, 32'd1);
        set_defaults(); ent_perm = 6'b001_110; msr_pr = 1; acc_type = 2'd1; run_access();
        check("R7 store prot code", {30'd0, result}, 32'd2);
        check("R7 prot flag", {31'd0, prot_fault}, 32'd1);
        check("R8 store syndrome", {31'd0, syn_store}, 32'd1);
        set_defaults(); ent_perm = 6'b001_110; msr_pr = 1; ext_mode = 1;
        ext_pid = 8'h05; ext_pr = 0; acc_type = 2'd1; run_access();
        check("R5 ext_pr selects supervisor", {30'd0, result}, 32'd0);
        set_defaults(); ent_perm = 6'b001_110; acc_type = 2'd3; run_access();
        check("R7 code 3 as load", {30'd0, result}, 32'd2);
    endtask

    task automatic t_as();
        set_defaults(); ent_ts = 1; run_access();
        check("R6 data ts mismatch", {30'd0, result}, 32'd1);
        check("R5 perm zero on miss", {29'd0, perm_out}, 32'd0);
        set_defaults(); ent_ts = 1; msr_ds = 1; run_access();
        check("R6 data ts match", {30'd0, result}, 32'd0);
        set_defaults(); ent_ts = 1; msr_ds = 1; acc_type = 2'd2; run_access();
        check("R6 fetch uses msr_is", {30'd0, result}, 32'd1);
        set_defaults(); ent_ts = 1; msr_ds = 0; ext_mode = 1; ext_pid = 8'h05; ext_as = 1; run_access();
        check("R6 ext_as used", {30'd0, result}, 32'd0);
    endtask

    task automatic t_fetch();
        set_defaults(); ent_perm = 6'b011_011; acc_type = 2'd2; run_access();
        check("R7 exec fault code", {30'd0, result}, 32'd3);
        check("R8 fetch syndrome", {30'd0, syn_store, syn_ext}, 32'd0);
        set_defaults(); acc_type = 2'd2; run_access();
        check("R7 fetch hit", {31'd0, hit}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_basic();
        t_pid_order();
        t_ext();
        t_addr();
        t_priv();
        t_as();
        t_fetch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule